// File: doc/BRIEF.md
# Virtual Timer Compare Unit

This block compares a free-running 64-bit virtual count against a programmed 64-bit deadline and raises a timer condition once the count has reached or passed that deadline. The test is not an equality match. The block forms the difference count minus deadline modulo 2^64 and reads bit 63 as a sign. A zero or positive difference means the deadline has been reached. A deadline that software programs late therefore fires at once and is never missed.

The count comes in on a port, and the block neither stores it nor stops it. Software programs the block through a small register port. Address 0 holds the 64-bit deadline. Address 1 holds the enable bit and the mask bit, and it also returns the live status bit. The block drives a level-sensitive interrupt, which is the status bit gated by the mask. The interrupt falls as soon as the deadline is moved into the future or the timer is switched off.

Top module: `vtmr_cmp_unit`

## Requirements
- R1: A write to address 0 loads all 64 bits of the deadline register on the next rising clock edge, and a read of address 0 returns those 64 bits unchanged. The deadline register has no reset value.
- R2: Address 1 is the control word: bit 0 is enable and bit 1 is mask, both read back as written, and bit 2 reads the live status; enable and mask are 0 after reset, so a read of address 1 then returns 0.
- R3: With enable at 1, status is 1 exactly when (count_in - deadline) mod 2^64 has bit 63 clear, i.e. the difference is zero or positive when read as a signed 64-bit number.
- R4: With enable at 0, status and the interrupt are 0 for every count and deadline value, and the count input keeps changing without any effect on the block.
- R5: timer_irq equals status AND NOT mask at all times; status itself is not affected by the mask.
- R6: A register write takes effect on the next rising edge, and status and the interrupt reflect the new value in the cycle that follows that edge. Moving the deadline ahead of the count drops a pending interrupt in that same cycle.
- R7: The signed reading holds across the wrap of the count. A difference of 2^63-1 gives status 1, a difference of 2^63 gives status 0, and a deadline near 2^64-1 is met once the count has wrapped past zero.
- R8: Writes to addresses 2 and 3 change no state and those addresses read 0. Writing bit 2 of the control word does not change status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control word |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address: 0 deadline, 1 control, 2-3 unused |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| count_in | input | 64 | Free-running virtual count |
| timer_status | output | 1 | Timer condition (enable and non-negative difference) |
| timer_irq | output | 1 | Level interrupt, status gated by mask |

## Verification
The deadline can be rewritten in the same cycle in which the count crosses the old or the new deadline, and the two effects must resolve together. The bench provokes this by loading a new deadline on the same rising edge on which it steps the count to exactly that value. It then expects status to be 1 right after that edge, taking no stale result from the old deadline. In the opposite case it moves the deadline one step beyond the count at that edge and expects the interrupt to be gone in the very next cycle.

// File: rtl/vtmr_pkg.sv
package vtmr_pkg;
   // register port address map
   localparam int unsigned ADDR_CMP  = 0;
   localparam int unsigned ADDR_CTRL = 1;

   // control word bit positions
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_MASK_BIT = 1;
   localparam int unsigned CTRL_STAT_BIT = 2;

   typedef struct packed {
      logic mask;
      logic en;
   } vtmr_ctrl_t;
endpackage

// File: rtl/vtmr_regs.sv
module vtmr_regs
   import vtmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  cmp_q,
   output vtmr_ctrl_t        ctrl_q
);
   localparam int unsigned NUM_REGS = 1 << ADDR_W;

   generate
      if (NUM_REGS < 2) begin : g_bad_addr
         $error("vtmr_regs: ADDR_W must decode at least two registers");
      end
      if (CNT_W <= CTRL_STAT_BIT) begin : g_bad_width
         $error("vtmr_regs: CNT_W too narrow for the control word");
      end
   endgenerate

   logic wr_cmp;
   logic wr_ctrl;

   assign wr_cmp  = wr && (addr == ADDR_W'(ADDR_CMP));
   assign wr_ctrl = wr && (addr == ADDR_W'(ADDR_CTRL));

   // deadline register: deliberately without reset
   always_ff @(posedge clk) begin
      if (wr_cmp) begin
         cmp_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.en   <= wdata[CTRL_EN_BIT];
         ctrl_q.mask <= wdata[CTRL_MASK_BIT];
      end
   end
endmodule

// File: rtl/vtmr_cmp_eval.sv
module vtmr_cmp_eval #(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned SLICE_W = 16
) (
   input  logic             en,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] deadline,
   output logic             met
);
   localparam int unsigned NSLICE = CNT_W / SLICE_W;

   generate
      if (SLICE_W == 0 || (CNT_W % SLICE_W) != 0) begin : g_bad_slice
         $error("vtmr_cmp_eval: SLICE_W must divide CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] diff;

   generate
      if (NSLICE <= 1) begin : g_flat
         // single wide subtractor
         assign diff = count - deadline;
      end else begin : g_sliced
         // borrow-chained slices, one per SLICE_W bits
         logic [NSLICE:0] borrow;
         assign borrow[0] = 1'b0;
         for (genvar s = 0; s < NSLICE; s++) begin : g_slice
            logic [SLICE_W:0] part;
            assign part = {1'b0, count[s*SLICE_W +: SLICE_W]}
                        - {1'b0, deadline[s*SLICE_W +: SLICE_W]}
                        - {{SLICE_W{1'b0}}, borrow[s]};
            assign diff[s*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            assign borrow[s+1] = part[SLICE_W];
         end
      end
   endgenerate

   // sign bit of the modular difference decides
   assign met = en & ~diff[CNT_W-1];
endmodule

// File: rtl/vtmr_cmp_unit.sv
module vtmr_cmp_unit
   import vtmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned SLICE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic [CNT_W-1:0]  count_in,
   output logic              timer_status,
   output logic              timer_irq
);
   localparam int unsigned CTRL_PAD = CNT_W - CTRL_STAT_BIT - 1;

   logic [CNT_W-1:0] cmp_q;
   vtmr_ctrl_t       ctrl_q;
   logic             en_q;
   logic             mask_q;

   vtmr_regs #(
      .CNT_W (CNT_W),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .cmp_q (cmp_q),
      .ctrl_q(ctrl_q)
   );

   assign en_q   = ctrl_q.en;
   assign mask_q = ctrl_q.mask;

   vtmr_cmp_eval #(
      .CNT_W  (CNT_W),
      .SLICE_W(SLICE_W)
   ) u_eval (
      .en      (en_q),
      .count   (count_in),
      .deadline(cmp_q),
      .met     (timer_status)
   );

   assign timer_irq = timer_status & ~mask_q;

   always_comb begin
      unique case (reg_addr)
         ADDR_W'(ADDR_CMP):  reg_rdata = cmp_q;
         ADDR_W'(ADDR_CTRL): reg_rdata = {{CTRL_PAD{1'b0}}, timer_status, mask_q, en_q};
         default:            reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/vtmr_cmp_chk.sv
module vtmr_cmp_chk #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [CNT_W-1:0]  reg_wdata,
   input logic [CNT_W-1:0]  reg_rdata,
   input logic [CNT_W-1:0]  count_in,
   input logic              timer_status,
   input logic              timer_irq,
   input logic              en_q,
   input logic [CNT_W-1:0]  cmp_q
);
   logic [CNT_W-1:0] gap;
   assign gap = count_in - cmp_q;

   // R1
   cmp_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0) |=> (reg_addr != '0 || reg_rdata == $past(reg_wdata)));

   // R3
   signed_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (timer_status == !gap[CNT_W-1]));

   // R4
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (!timer_status && !timer_irq));

   // R5
   irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timer_irq |-> timer_status);

   // R6
   disable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(1) && !reg_wdata[0]) |=> !timer_status);
endmodule

bind vtmr_cmp_unit vtmr_cmp_chk #(
   .CNT_W (CNT_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .count_in    (count_in),
   .timer_status(timer_status),
   .timer_irq   (timer_irq),
   .en_q        (en_q),
   .cmp_q       (cmp_q)
);

// File: tb/test_vtmr_cmp_unit.sv
module test_vtmr_cmp_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [63:0] count_in = '0;
   logic        timer_status;
   logic        timer_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vtmr_cmp_unit i_vtmr_cmp_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .count_in    (count_in),
      .timer_status(timer_status),
      .timer_irq   (timer_irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
      end
   endtask

   // write lands on the next rising edge; returns 1 time unit after it
   task automatic reg_write(input logic [1:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_count(input logic [63:0] c);
      @(negedge clk);
      count_in = c;
      #1;
   endtask

   task automatic t_reset;
      logic [63:0] d;
      reg_read(2'd1, d);
      check("R2 reset ctrl", d, 64'd0);
      check("R4 reset status", {63'd0, timer_status}, 64'd0);
      check("R4 reset irq", {63'd0, timer_irq}, 64'd0);
   endtask

   task automatic t_cmp_rw;
      logic [63:0] d;
      reg_write(2'd0, 64'hDEAD_BEEF_1234_5678);
      reg_read(2'd0, d);
      check("R1 readback", d, 64'hDEAD_BEEF_1234_5678);
      reg_write(2'd0, 64'h8000_0000_0000_0001);
      reg_read(2'd0, d);
      check("R1 readback msb", d, 64'h8000_0000_0000_0001);
   endtask

   task automatic t_disabled;
      reg_write(2'd0, 64'd100);
      reg_write(2'd1, 64'd0);
      for (int i = 0; i < 5; i++) begin
         set_count(64'd90 + 64'(i * 20));
         check("R4 disabled status", {63'd0, timer_status}, 64'd0);
         check("R4 disabled irq", {63'd0, timer_irq}, 64'd0);
      end
   endtask

   task automatic t_basic;
      logic [63:0] d;
      reg_write(2'd0, 64'd1000);
      set_count(64'd999);
      reg_write(2'd1, 64'h1);
      check("R3 before deadline", {63'd0, timer_status}, 64'd0);
      set_count(64'd1000);
      check("R3 at deadline", {63'd0, timer_status}, 64'd1);
      check("R5 irq unmasked", {63'd0, timer_irq}, 64'd1);
      set_count(64'd1001);
      check("R3 past deadline", {63'd0, timer_status}, 64'd1);
      reg_write(2'd1, 64'h3);
      check("R5 masked irq", {63'd0, timer_irq}, 64'd0);
      check("R5 masked status", {63'd0, timer_status}, 64'd1);
      reg_read(2'd1, d);
      check("R2 ctrl read", d, 64'h7);
      reg_write(2'd1, 64'h1);
      check("R5 unmask irq", {63'd0, timer_irq}, 64'd1);
   endtask

   task automatic t_rewrite;
      // irq pending; before the edge of the write it is still high
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 64'd5000;
      #1;
      check("R6 old value before edge", {63'd0, timer_irq}, 64'd1);
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
      check("R6 future deadline drops irq", {63'd0, timer_irq}, 64'd0);
      // deadline write and count step on the same edge
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 64'd7000;
      @(posedge clk);
      count_in = 64'd7000;
      #1;
      reg_wr = 1'b0;
      check("R6 same-edge write and crossing", {63'd0, timer_status}, 64'd1);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 64'd7002;
      @(posedge clk);
      count_in = 64'd7001;
      #1;
      reg_wr = 1'b0;
      check("R6 same-edge one ahead", {63'd0, timer_irq}, 64'd0);
   endtask

   task automatic t_wrap;
      reg_write(2'd0, 64'hFFFF_FFFF_FFFF_FFF0);
      set_count(64'hFFFF_FFFF_FFFF_FFEF);
      check("R7 just before near-top deadline", {63'd0, timer_status}, 64'd0);
      set_count(64'h0000_0000_0000_0005);
      check("R7 met after count wrap", {63'd0, timer_status}, 64'd1);
      reg_write(2'd0, 64'd0);
      set_count(64'h7FFF_FFFF_FFFF_FFFF);
      check("R7 diff 2^63-1", {63'd0, timer_status}, 64'd1);
      set_count(64'h8000_0000_0000_0000);
      check("R7 diff 2^63", {63'd0, timer_status}, 64'd0);
   endtask

   task automatic t_ignore;
      logic [63:0] d;
      reg_write(2'd0, 64'h0000_0000_0000_4000);
      set_count(64'h0000_0000_0000_3000);
      reg_write(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      reg_write(2'd3, 64'h1234);
      reg_read(2'd2, d);
      check("R8 addr2 reads zero", d, 64'd0);
      reg_read(2'd3, d);
      check("R8 addr3 reads zero", d, 64'd0);
      reg_read(2'd0, d);
      check("R8 deadline kept", d, 64'h4000);
      reg_read(2'd1, d);
      check("R8 ctrl kept", d, 64'h1);
      reg_write(2'd1, 64'h5);
      check("R8 status bit not writable", {63'd0, timer_status}, 64'd0);
   endtask

   initial begin : watchdog
      for (int i = 0; i < WATCHDOG; i++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cmp_rw();
      t_disabled();
      t_basic();
      t_rewrite();
      t_wrap();
      t_ignore();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule